// File: doc/BRIEF.md
# Destination Address Filter with Hash Tables

This block sits on the receive side of an Ethernet MAC and decides, from the six destination-address bytes at the head of each frame, whether that frame is kept. The bytes arrive one per valid cycle, the first of them marked by a start strobe. When the sixth byte is taken, the block makes a single registered decision and reports three things: whether the frame is accepted, what kind of destination it carries (broadcast or multicast), and whether it was only let through because of the promiscuous override.

A unicast address is accepted if it matches the programmed station address. If it does not match, it can still be accepted through a 64-entry individual hash table. A multicast address is accepted through a 64-entry group hash table. Both tables are indexed by the top bits of a CRC-32 computed over the address bytes. An all-ones address is accepted unless the broadcast-reject control is set. The promiscuous control forces acceptance of every frame.

The configuration inputs are expected to hold steady while an address is streaming in.

Top module: `daf_filter`

## Requirements
- R1: While reset is low and after it is released, `res_valid`, `res_accept`, `res_miss`, `res_bcast` and `res_mcast` are all 0 until the first result.
- R2: Framing works as follows.
  - A cycle with `in_valid` and `in_start` high takes the first address byte. A run in progress is abandoned when a new start appears.
  - Valid bytes without a start while no run is active are ignored.
  - Cycles with `in_valid` low are skipped.
  - `res_valid` is high for exactly the one cycle after the clock edge that takes the sixth byte.
- R3: The station address is mapped onto the configuration ports as follows.
  - Address bytes 0 to 3 (byte 0 first on the wire) are compared with `sta_lo[31:24]`, `[23:16]`, `[15:8]` and `[7:0]`.
  - Bytes 4 and 5 are compared with `sta_hi[15:8]` and `[7:0]`.
  - A unicast address equal to the station address is accepted with `res_miss` at 0.
- R4: Address types are flagged as follows.
  - An address whose byte 0 has bit 0 set is a group address.
  - The all-ones address sets `res_bcast` and clears `res_mcast`.
  - Any other group address sets `res_mcast` and clears `res_bcast`.
  - A unicast address clears both flags.
- R5: A multicast address is accepted exactly when its entry in the group table is 1. The entry is found as follows.
  - The hash index is bits 31:26 of the CRC register after all six bytes. The CRC uses the reflected polynomial 0xEDB88320, starts at all ones, takes each byte least significant bit first, and has no final inversion.
  - Index 0..31 selects `grp_lo[index]`.
  - Index 32..63 selects `grp_hi[index-32]`.
- R6: A unicast address that differs from the station address is accepted exactly when `ind_lo`/`ind_hi` has the bit selected by the same index rule as in R5.
- R7: The broadcast address ignores both hash tables. It is accepted when `cfg_bc_rej` is 0 and rejected when it is 1.
- R8: With `cfg_prom` at 1 every address is accepted. In that mode `res_miss` is 1 exactly when the frame would have been rejected with `cfg_prom` at 0. With `cfg_prom` at 0, `res_miss` is 0.
- R9: `res_accept`, `res_miss`, `res_bcast` and `res_mcast` keep their values in every cycle in which `res_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Address byte present on `in_byte` |
| in_start | input | 1 | Marks the first address byte of a frame |
| in_byte | input | 8 | Destination-address byte, first-on-wire order |
| sta_lo | input | 32 | Station address bytes 0..3, byte 0 in bits 31:24 |
| sta_hi | input | 16 | Station address bytes 4..5, byte 4 in bits 15:8 |
| grp_lo | input | REG_W | Group hash table entries 0..31 |
| grp_hi | input | REG_W | Group hash table entries 32..63 |
| ind_lo | input | REG_W | Individual hash table entries 0..31 |
| ind_hi | input | REG_W | Individual hash table entries 32..63 |
| cfg_prom | input | 1 | Promiscuous: accept everything |
| cfg_bc_rej | input | 1 | Reject the broadcast address |
| res_valid | output | 1 | One-cycle pulse: decision flags updated |
| res_accept | output | 1 | Frame is to be kept |
| res_miss | output | 1 | Kept only because of promiscuous mode |
| res_bcast | output | 1 | Destination is the broadcast address |
| res_mcast | output | 1 | Destination is a non-broadcast group address |

## Verification
Several acceptance paths can meet in one decision, and the bench provokes each such meeting on purpose.

- Promiscuous override meets broadcast reject: an all-ones address is sent with both controls set. The result is judged correct only if the frame is accepted and the miss flag is raised, since without the override it would have been dropped.
- Promiscuous override meets a station match: a matching unicast is sent in promiscuous mode. Here the miss flag must stay clear, because the frame would have been kept anyway.
- Broadcast meets the group table: a broadcast is sent with the group table fully set while broadcast reject is active. It must still be dropped, which shows the table is not consulted for broadcasts.
- Framing under disturbance: a start strobe arrives partway through an address, and bytes arrive with idle gaps. The bench checks that exactly one result pulse comes out, and that it reflects only the restarted address.

// File: rtl/daf_pkg.sv
package daf_pkg;

   localparam int ADDR_BYTES = 6;
   localparam int ADDR_W     = ADDR_BYTES * 8;
   localparam int CRC_W      = 32;

   typedef struct packed {
      logic accept;
      logic miss;
      logic bcast;
      logic mcast;
   } daf_res_t;

endpackage

// File: rtl/daf_crc8.sv
// One byte of a reflected CRC, unrolled bit by bit (LSB of the byte first).
module daf_crc8 #(
   parameter int               CRC_W = 32,
   parameter logic [CRC_W-1:0] POLY  = 32'hEDB88320
) (
   input  logic [CRC_W-1:0] crc_in,
   input  logic [7:0]       data,
   output logic [CRC_W-1:0] crc_out
);

   logic [CRC_W-1:0] stage [0:8];

   assign stage[0] = crc_in;

   for (genvar i = 0; i < 8; i++) begin : g_bit
      assign stage[i+1] = (stage[i] >> 1) ^ ({CRC_W{stage[i][0] ^ data[i]}} & POLY);
   end

   assign crc_out = stage[8];

endmodule

// File: rtl/daf_collect.sv
// Gathers the address bytes, runs the CRC and flags the completing byte.
module daf_collect
   import daf_pkg::*;
#(
   parameter logic [CRC_W-1:0] POLY = 32'hEDB88320
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic              in_start,
   input  logic [7:0]        in_byte,
   output logic              last,
   output logic [ADDR_W-1:0] addr_full,
   output logic [CRC_W-1:0]  crc_full
);

   localparam int SR_W  = (ADDR_BYTES - 1) * 8;
   localparam int CNT_W = $clog2(ADDR_BYTES + 1);

   logic [CNT_W-1:0] cnt_q;
   logic [SR_W-1:0]  sr_q;
   logic [CRC_W-1:0] crc_q;
   logic [CRC_W-1:0] crc_seed;
   logic             busy;
   logic             take;

   assign busy     = (cnt_q != '0);
   assign take     = in_valid & (in_start | busy);
   assign last     = take & ~in_start & (cnt_q == CNT_W'(ADDR_BYTES - 1));
   assign crc_seed = in_start ? {CRC_W{1'b1}} : crc_q;

   daf_crc8 #(.CRC_W(CRC_W), .POLY(POLY)) u_crc (
      .crc_in  (crc_seed),
      .data    (in_byte),
      .crc_out (crc_full)
   );

   assign addr_full = {sr_q, in_byte};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
         sr_q  <= '0;
         crc_q <= '1;
      end else if (take) begin
         sr_q  <= {sr_q[SR_W-9:0], in_byte};
         crc_q <= crc_full;
         if (last)
            cnt_q <= '0;
         else if (in_start)
            cnt_q <= CNT_W'(1);
         else
            cnt_q <= cnt_q + CNT_W'(1);
      end
   end

endmodule

// File: rtl/daf_decide.sv
// Combinational acceptance decision for one complete address.
module daf_decide
   import daf_pkg::*;
#(
   parameter int HASH_BITS = 6,
   parameter int REG_W     = (1 << HASH_BITS) / 2
) (
   input  logic [ADDR_W-1:0]    addr,
   input  logic [HASH_BITS-1:0] idx,
   input  logic [31:0]          sta_lo,
   input  logic [15:0]          sta_hi,
   input  logic [REG_W-1:0]     grp_lo,
   input  logic [REG_W-1:0]     grp_hi,
   input  logic [REG_W-1:0]     ind_lo,
   input  logic [REG_W-1:0]     ind_hi,
   input  logic                 prom,
   input  logic                 bc_rej,
   output daf_res_t             res
);

   logic [ADDR_W-1:0]     station;
   logic [ADDR_BYTES-1:0] byte_eq;
   logic                  sta_match;
   logic                  is_group;
   logic                  is_bcast;
   logic                  is_mcast;
   logic                  grp_bit;
   logic                  ind_bit;
   logic                  hit;
   logic [HASH_BITS-2:0]  sub;

   assign station = {sta_lo, sta_hi};

   for (genvar b = 0; b < ADDR_BYTES; b++) begin : g_byte
      assign byte_eq[b] = (addr[b*8 +: 8] == station[b*8 +: 8]);
   end

   assign sta_match = &byte_eq;
   assign is_group  = addr[ADDR_W-8];
   assign is_bcast  = &addr;
   assign is_mcast  = is_group & ~is_bcast;

   assign sub     = idx[HASH_BITS-2:0];
   assign grp_bit = idx[HASH_BITS-1] ? grp_hi[sub] : grp_lo[sub];
   assign ind_bit = idx[HASH_BITS-1] ? ind_hi[sub] : ind_lo[sub];

   always_comb begin
      if (is_bcast)
         hit = ~bc_rej;
      else if (is_group)
         hit = grp_bit;
      else
         hit = sta_match | ind_bit;
   end

   assign res.accept = hit | prom;
   assign res.miss   = prom & ~hit;
   assign res.bcast  = is_bcast;
   assign res.mcast  = is_mcast;

endmodule

// File: rtl/daf_filter.sv
module daf_filter
   import daf_pkg::*;
#(
   parameter int               HASH_BITS = 6,
   parameter logic [CRC_W-1:0] CRC_POLY  = 32'hEDB88320,
   localparam int              REG_W     = (1 << HASH_BITS) / 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic             in_start,
   input  logic [7:0]       in_byte,
   input  logic [31:0]      sta_lo,
   input  logic [15:0]      sta_hi,
   input  logic [REG_W-1:0] grp_lo,
   input  logic [REG_W-1:0] grp_hi,
   input  logic [REG_W-1:0] ind_lo,
   input  logic [REG_W-1:0] ind_hi,
   input  logic             cfg_prom,
   input  logic             cfg_bc_rej,
   output logic             res_valid,
   output logic             res_accept,
   output logic             res_miss,
   output logic             res_bcast,
   output logic             res_mcast
);

   if (HASH_BITS < 2 || HASH_BITS > 16) begin : g_bad_hash
      $error("daf_filter: HASH_BITS must lie in 2..16");
   end

   logic              last;
   logic [ADDR_W-1:0] addr_full;
   logic [CRC_W-1:0]  crc_full;
   daf_res_t          res_d;
   daf_res_t          res_q;
   logic              valid_q;

   daf_collect #(.POLY(CRC_POLY)) u_collect (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .in_start  (in_start),
      .in_byte   (in_byte),
      .last      (last),
      .addr_full (addr_full),
      .crc_full  (crc_full)
   );

   daf_decide #(.HASH_BITS(HASH_BITS), .REG_W(REG_W)) u_decide (
      .addr   (addr_full),
      .idx    (crc_full[CRC_W-1 -: HASH_BITS]),
      .sta_lo (sta_lo),
      .sta_hi (sta_hi),
      .grp_lo (grp_lo),
      .grp_hi (grp_hi),
      .ind_lo (ind_lo),
      .ind_hi (ind_hi),
      .prom   (cfg_prom),
      .bc_rej (cfg_bc_rej),
      .res    (res_d)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_q <= 1'b0;
         res_q   <= '0;
      end else begin
         valid_q <= last;
         if (last)
            res_q <= res_d;
      end
   end

   assign res_valid  = valid_q;
   assign res_accept = res_q.accept;
   assign res_miss   = res_q.miss;
   assign res_bcast  = res_q.bcast;
   assign res_mcast  = res_q.mcast;

endmodule

// File: rtl/daf_filter_chk.sv
module daf_filter_chk (
   input logic clk,
   input logic rst_n,
   input logic in_valid,
   input logic cfg_prom,
   input logic cfg_bc_rej,
   input logic res_valid,
   input logic res_accept,
   input logic res_miss,
   input logic res_bcast,
   input logic res_mcast
);

   // R2
   pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |=> !res_valid);

   // R2
   pulse_follows_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> $past(in_valid));

   // R4
   type_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(res_bcast && res_mcast));

   // R7
   bcast_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && res_bcast && $past(cfg_bc_rej) && !$past(cfg_prom)) |-> !res_accept);

   // R8
   prom_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && $past(cfg_prom)) |-> (res_accept));

   // R8
   miss_needs_prom_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && !$past(cfg_prom)) |-> !res_miss);

   // R9
   flags_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !res_valid |-> $stable({res_accept, res_miss, res_bcast, res_mcast}));

endmodule

bind daf_filter daf_filter_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .in_valid   (in_valid),
   .cfg_prom   (cfg_prom),
   .cfg_bc_rej (cfg_bc_rej),
   .res_valid  (res_valid),
   .res_accept (res_accept),
   .res_miss   (res_miss),
   .res_bcast  (res_bcast),
   .res_mcast  (res_mcast)
);

// File: tb/daf_filter_test.sv
`timescale 1ns/1ps
module daf_filter_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic        in_start = 1'b0;
   logic [7:0]  in_byte = '0;
   logic [31:0] sta_lo = '0;
   logic [15:0] sta_hi = '0;
   logic [31:0] grp_lo = '0;
   logic [31:0] grp_hi = '0;
   logic [31:0] ind_lo = '0;
   logic [31:0] ind_hi = '0;
   logic        cfg_prom = 1'b0;
   logic        cfg_bc_rej = 1'b0;
   logic        res_valid, res_accept, res_miss, res_bcast, res_mcast;

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   localparam logic [47:0] STATION = 48'h02_11_22_33_44_55;
   localparam logic [47:0] BCAST   = 48'hFF_FF_FF_FF_FF_FF;

   always #2.5 clk = ~clk;

   daf_filter uut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_start(in_start),
      .in_byte(in_byte), .sta_lo(sta_lo), .sta_hi(sta_hi),
      .grp_lo(grp_lo), .grp_hi(grp_hi), .ind_lo(ind_lo), .ind_hi(ind_hi),
      .cfg_prom(cfg_prom), .cfg_bc_rej(cfg_bc_rej),
      .res_valid(res_valid), .res_accept(res_accept), .res_miss(res_miss),
      .res_bcast(res_bcast), .res_mcast(res_mcast)
   );

   task automatic chk(input string req, input string what, input logic act, input logic exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0b expected %0b", req, what, act, exp);
      end
   endtask

   // Hash index per R5: reflected CRC-32, init all ones, LSB first, bits 31:26.
   function automatic logic [5:0] hidx(input logic [47:0] a);
      logic [31:0] c = 32'hFFFF_FFFF;
      for (int b = 0; b < 6; b++) begin
         logic [7:0] d = a[47-8*b -: 8];
         for (int i = 0; i < 8; i++) begin
            logic fb = c[0] ^ d[i];
            c = c >> 1;
            if (fb) c = c ^ 32'hEDB8_8320;
         end
      end
      return c[31:26];
   endfunction

   function automatic logic [63:0] one_bit(input logic [5:0] i);
      return 64'd1 << i;
   endfunction

   task automatic set_tables(input logic [63:0] grp, input logic [63:0] ind);
      @(negedge clk);
      grp_lo = grp[31:0]; grp_hi = grp[63:32];
      ind_lo = ind[31:0]; ind_hi = ind[63:32];
   endtask

   task automatic drive(input logic [7:0] b, input logic st);
      @(negedge clk);
      in_valid = 1'b1; in_start = st; in_byte = b;
   endtask

   task automatic idle(input int n);
      for (int k = 0; k < n; k++) begin
         @(negedge clk);
         in_valid = 1'b0; in_start = 1'b0;
      end
   endtask

   // Sends one address; returns at the negedge where the result is visible.
   task automatic send(input logic [47:0] a, input int gap);
      for (int i = 0; i < 6; i++) begin
         drive(a[47-8*i -: 8], i == 0);
         if (gap > 0 && i < 5) idle(gap);
      end
      @(negedge clk);
      in_valid = 1'b0; in_start = 1'b0;
   endtask

   task automatic expect_res(input string req, input logic acc, input logic miss,
                             input logic bc, input logic mc);
      chk(req, "res_valid", res_valid, 1'b1);
      chk(req, "res_accept", res_accept, acc);
      chk(req, "res_miss", res_miss, miss);
      chk(req, "res_bcast", res_bcast, bc);
      chk(req, "res_mcast", res_mcast, mc);
   endtask

   task automatic t_reset();
      // R1
      chk("R1", "res_valid", res_valid, 1'b0);
      chk("R1", "res_accept", res_accept, 1'b0);
      chk("R1", "res_miss", res_miss, 1'b0);
      chk("R1", "res_bcast", res_bcast, 1'b0);
      chk("R1", "res_mcast", res_mcast, 1'b0);
   endtask

   task automatic t_station();
      set_tables('0, '0);
      send(STATION, 0);
      expect_res("R3", 1'b1, 1'b0, 1'b0, 1'b0);
      send(STATION ^ 48'h00_00_00_00_01_00, 0);   // byte 4 differs
      expect_res("R3", 1'b0, 1'b0, 1'b0, 1'b0);
      send(STATION ^ 48'h00_00_00_80_00_00, 0);   // byte 3 differs
      expect_res("R3", 1'b0, 1'b0, 1'b0, 1'b0);
   endtask

   task automatic t_ind_hash();
      logic [47:0] a = 48'h00_AA_BB_CC_DD_EE;
      set_tables('1, one_bit(hidx(a)));
      send(a, 0);
      expect_res("R6", 1'b1, 1'b0, 1'b0, 1'b0);
      set_tables('1, ~one_bit(hidx(a)));
      send(a, 0);
      expect_res("R6", 1'b0, 1'b0, 1'b0, 1'b0);
   endtask

   task automatic t_grp_hash();
      logic [47:0] m1 = 48'h01_00_5E_00_00_01;
      logic [47:0] m2 = 48'h33_33_00_00_00_FB;
      set_tables(one_bit(hidx(m1)), '1);
      send(m1, 0);
      expect_res("R5", 1'b1, 1'b0, 1'b0, 1'b1);
      set_tables(~one_bit(hidx(m1)), '1);
      send(m1, 0);
      expect_res("R5", 1'b0, 1'b0, 1'b0, 1'b1);
      set_tables(one_bit(hidx(m2)), '0);
      send(m2, 0);
      expect_res("R5", 1'b1, 1'b0, 1'b0, 1'b1);
      set_tables(~one_bit(hidx(m2)), '0);
      send(m2, 0);
      expect_res("R5", 1'b0, 1'b0, 1'b0, 1'b1);
   endtask

   task automatic t_bcast();
      set_tables('0, '0);
      cfg_bc_rej = 1'b0;
      send(BCAST, 0);
      expect_res("R7", 1'b1, 1'b0, 1'b1, 1'b0);
      set_tables('1, '1);
      cfg_bc_rej = 1'b1;
      send(BCAST, 0);
      expect_res("R7", 1'b0, 1'b0, 1'b1, 1'b0);
      // R4: one low bit elsewhere makes it plain multicast
      set_tables('0, '0);
      send(BCAST ^ 48'h00_00_00_00_00_01, 0);
      expect_res("R4", 1'b0, 1'b0, 1'b0, 1'b1);
   endtask

   task automatic t_prom();
      cfg_prom = 1'b1;
      cfg_bc_rej = 1'b1;
      set_tables('0, '0);
      send(BCAST, 0);
      expect_res("R8", 1'b1, 1'b1, 1'b1, 1'b0);
      send(STATION, 0);
      expect_res("R8", 1'b1, 1'b0, 1'b0, 1'b0);
      send(48'h00_12_34_56_78_9A, 0);
      expect_res("R8", 1'b1, 1'b1, 1'b0, 1'b0);
      cfg_prom = 1'b0;
      cfg_bc_rej = 1'b0;
   endtask

   task automatic t_framing();
      set_tables('0, '0);
      // gaps between bytes
      send(STATION, 2);
      expect_res("R2", 1'b1, 1'b0, 1'b0, 1'b0);
      @(negedge clk);
      chk("R2", "single pulse", res_valid, 1'b0);
      // restart partway through an unmatched address
      drive(8'h00, 1'b1); drive(8'h99, 1'b0); drive(8'h99, 1'b0);
      @(negedge clk); in_valid = 1'b0;
      chk("R2", "no result on partial", res_valid, 1'b0);
      send(STATION, 0);
      expect_res("R2", 1'b1, 1'b0, 1'b0, 1'b0);
      // stray bytes with no start while idle: no result, flags untouched
      send(48'h00_12_34_56_78_9A, 0);
      expect_res("R2", 1'b0, 1'b0, 1'b0, 1'b0);
      begin
         int pulses = 0;
         for (int i = 0; i < 7; i++) begin
            @(negedge clk);
            in_valid = 1'b1; in_start = 1'b0; in_byte = STATION[47-8*(i%6) -: 8];
            if (res_valid) pulses++;
         end
         @(negedge clk); in_valid = 1'b0;
         if (res_valid) pulses++;
         chk("R2", "stray bytes ignored", pulses != 0, 1'b0);
         chk("R9", "accept held", res_accept, 1'b0);
      end
   endtask

   task automatic t_hold();
      set_tables('0, '0);
      send(BCAST, 0);
      expect_res("R9", 1'b1, 1'b0, 1'b1, 1'b0);
      idle(4);
      chk("R9", "res_accept held", res_accept, 1'b1);
      chk("R9", "res_bcast held", res_bcast, 1'b1);
      chk("R9", "res_valid low", res_valid, 1'b0);
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
   endtask

   initial begin
      sta_lo = STATION[47:16];
      sta_hi = STATION[15:0];
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_station();
      t_ind_hash();
      t_grp_hash();
      t_bcast();
      t_prom();
      t_framing();
      t_hold();
      finished = 1'b1;
      summary();
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         summary();
         $finish;
      end
   end

endmodule